// File: doc/BRIEF.md
# Lock Reservation Unit for Load-Linked / Store-Conditional

This unit sits at the home tile of a group of lock words. It provides load-linked and store-conditional semantics without any hardware cache coherence. Every lock word in the pages owned by the tile shares one reservation register. That register records the requester that linked, the word it linked, and a down-counting lifetime. A reservation that is already held cannot be taken over by another requester, so two competing lockers cannot keep cancelling each other. A requester that stalls while holding the reservation loses it when the lifetime runs out, so the lock cannot be held forever.

Requests arrive one per cycle. Each request carries an opcode, a requester tag, a word index and write data. Every request receives exactly one response in the following cycle. The response echoes the tag and returns the word as it stood before the request, together with an outcome flag. For a linked load, the flag says whether the reservation was granted. For a conditional store, it says whether the store succeeded. Plain loads and plain stores set the flag to 1. The lock words are held in a small register file inside the unit.

Top module: `lock_resv_unit`

## Requirements
- R1: After reset no reservation is held, `rsp_valid` is 0, and every word of the store reads 0.
- R2: A request accepted with `req_valid`=1 produces `rsp_valid`=1 exactly one cycle later. That response carries the same `rsp_id` as the request and, as `rsp_data`, the word at `req_addr` as it stood before the request. With `req_valid`=0 no response is produced.
- R3: A linked load (`req_op`=2'b10) arriving while no live reservation exists returns `rsp_ok`=1 and reserves the tag and word for that requester.
- R4: A linked load from a tag other than the holder's, arriving while a reservation is live, still returns the data. It returns `rsp_ok`=0 and leaves the reservation unchanged.
- R5: A conditional store (`req_op`=2'b11) succeeds only when a live reservation matches both its tag and its word. On success it writes `req_wdata`, returns `rsp_ok`=1 and clears the reservation.
- R6: A conditional store that does not match writes nothing, returns `rsp_ok`=0 and leaves any reservation unchanged.
- R7: A reservation set at a clock edge can be used by a request sampled at any of the next TIMEOUT edges. At the edge after those it has expired, and a new linked load from any requester is granted.
- R8: A plain store (`req_op`=2'b01) always writes and returns `rsp_ok`=1. If it hits the reserved word, it clears the reservation. A plain store to any other word leaves the reservation intact.
- R9: A linked load from the current holder moves the reservation to the new word and restarts the lifetime. It returns `rsp_ok`=1.
- R10: A plain load (`req_op`=2'b00) returns the word with `rsp_ok`=1 and leaves the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 plain load, 01 plain store, 10 linked load, 11 conditional store |
| req_id | input | ID_W | Requester tag |
| req_addr | input | ADDR_W | Lock word index |
| req_wdata | input | DATA_W | Write data for stores |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | Echoed requester tag |
| rsp_data | output | DATA_W | Word value before the request |
| rsp_ok | output | 1 | Reservation granted, conditional store succeeded, or 1 for plain operations |

## Verification
The hardest situation to reach is the exact lifetime boundary: a conditional store or a competing linked load has to land on the last usable edge, or on the first expired edge, of a reservation. The stimulus sets a small TIMEOUT. It then counts idle cycles after a grant so that the matching store arrives exactly on edge TIMEOUT in one run and on edge TIMEOUT+1 in another. A second sequence refreshes a reservation partway through its lifetime and then stores after the original lifetime would have run out. A long mixed sequence then drives colliding tags and words, and every response is checked against a behavioural model.

// File: rtl/lock_resv_pkg.sv
package lock_resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } req_op_e;
endpackage

// File: rtl/resv_tracker.sv
module resv_tracker
  import lock_resv_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 4,
  parameter int TMO_W   = 16,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              link_grant,
  output logic              cond_pass
);
  localparam logic [TMO_W-1:0] LIFE_LOAD = TMO_W'(TIMEOUT);
  localparam logic [TMO_W-1:0] ONE       = TMO_W'(1);

  logic              held_q, held_d;
  logic [ID_W-1:0]   owner_q, owner_d;
  logic [ADDR_W-1:0] word_q, word_d;
  logic [TMO_W-1:0]  life_q, life_d;

  logic expired, live, owner_hit, word_hit;
  logic is_link, is_cond, is_store, store_kill;

  always_comb begin
    is_link    = req_valid && (req_op == OP_LINK);
    is_cond    = req_valid && (req_op == OP_COND);
    is_store   = req_valid && (req_op == OP_STORE);
    expired    = held_q && (life_q == '0);
    live       = held_q && !expired;
    owner_hit  = live && (owner_q == req_id);
    word_hit   = live && (word_q == req_addr);
    link_grant = is_link && (!live || owner_hit);
    cond_pass  = is_cond && owner_hit && word_hit;
    store_kill = is_store && word_hit;
  end

  // next-state process
  always_comb begin
    held_d  = live;
    owner_d = owner_q;
    word_d  = word_q;
    life_d  = live ? (life_q - ONE) : life_q;
    if (link_grant) begin
      held_d  = 1'b1;
      owner_d = req_id;
      word_d  = req_addr;
      life_d  = LIFE_LOAD;
    end else if (cond_pass || store_kill) begin
      held_d = 1'b0;
    end
  end

  logic upd_en;
  assign upd_en = held_q || link_grant;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
      word_q  <= '0;
      life_q  <= '0;
    end else if (upd_en) begin
      held_q  <= held_d;
      owner_q <= owner_d;
      word_q  <= word_d;
      life_q  <= life_d;
    end
  end

  // R4
  foreign_link_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_link && live && (owner_q != req_id)) |=> (held_q && $stable(owner_q) && $stable(word_q)));
  // R5
  cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_pass |=> !held_q);
  // R7
  expiry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !is_link) |=> !held_q);
  // R7
  life_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> (life_q <= LIFE_LOAD));
  // R8
  store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_kill |=> !held_q);
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words_q[g] <= '0;
      else if (hit) words_q[g] <= wdata;
    end
  end

  assign rdata = words_q[addr];
endmodule

// File: rtl/lock_resv_unit.sv
module lock_resv_unit
  import lock_resv_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int TMO_W   = 16,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ok
);
  logic              link_grant, cond_pass, wr_en, ok_d;
  logic [DATA_W-1:0] rd_word;

  resv_tracker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TMO_W(TMO_W), .TIMEOUT(TIMEOUT)) u_track (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_id(req_id), .req_addr(req_addr), .link_grant(link_grant), .cond_pass(cond_pass)
  );

  assign wr_en = req_valid && ((req_op == OP_STORE) || cond_pass);

  word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .rdata(rd_word)
  );

  always_comb begin
    unique case (req_op)
      OP_LINK: ok_d = link_grant;
      OP_COND: ok_d = cond_pass;
      default: ok_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_id   <= req_id;
        rsp_data <= rd_word;
        rsp_ok   <= ok_d;
      end
    end
  end

  // R6
  cond_fail_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_COND) && !cond_pass) |-> !wr_en);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid && (rsp_id == $past(req_id))));
endmodule

// File: tb/lock_resv_unit_tb_top.sv
module lock_resv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 3, ADDR_W = 4, DATA_W = 16, TMO_W = 16, TIMEOUT = 20;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [ID_W-1:0] req_id = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [DATA_W-1:0] req_wdata = 0;
  logic rsp_valid, rsp_ok;
  logic [ID_W-1:0] rsp_id;
  logic [DATA_W-1:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_resv_unit #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W),
                   .TIMEOUT(TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_id(req_id),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .rsp_ok(rsp_ok));

  int checks = 0, fails = 0;
  string tag = "R1";

  // behavioural reference model
  int  m_mem [DEPTH];
  bit  m_held;
  int  m_owner, m_word, m_life;
  bit  e_valid, e_ok;
  int  e_id, e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_held = 0; m_life = 0; e_valid = 0;
    end else begin
      bit live;
      live = m_held && (m_life != 0);
      if (live) m_life = m_life - 1; else m_held = 0;
      e_valid = req_valid;
      if (req_valid) begin
        e_id = req_id; e_data = m_mem[req_addr]; e_ok = 1;
        case (req_op)
          2'b01: begin
            m_mem[req_addr] = req_wdata;
            if (live && m_word == req_addr) m_held = 0;
          end
          2'b10: begin
            if (!live || m_owner == req_id) begin
              m_held = 1; m_owner = req_id; m_word = req_addr; m_life = TIMEOUT;
            end else e_ok = 0;
          end
          2'b11: begin
            if (live && m_owner == req_id && m_word == req_addr) begin
              m_mem[req_addr] = req_wdata; m_held = 0;
            end else e_ok = 0;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic fail_line(string what, int act, int exp);
    fails++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (rsp_valid !== e_valid) fail_line("rsp_valid", rsp_valid, e_valid);
    else if (e_valid) begin
      if (rsp_id !== ID_W'(e_id)) fail_line("rsp_id (R2)", rsp_id, e_id);
      else if (rsp_data !== DATA_W'(e_data)) fail_line("rsp_data", rsp_data, e_data);
      else if (rsp_ok !== e_ok) fail_line("rsp_ok", rsp_ok, e_ok);
    end
  end

  task automatic req(input int op, input int id, input int addr, input int wd);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_id = ID_W'(id); req_addr = ADDR_W'(addr);
    req_wdata = DATA_W'(wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  int wd_cnt = 0;
  bit done = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle output and zero words after reset
    tag = "R1"; idle(2);
    req(0, 1, 3, 0); req(0, 1, 15, 0);
    // R3, R4, R6, R10, R5
    tag = "R3"; req(2, 1, 5, 0);
    tag = "R4"; req(2, 2, 5, 0);
    tag = "R6"; req(3, 2, 5, 16'h1234); req(3, 1, 6, 16'h5555);
    tag = "R10"; req(0, 3, 5, 0);
    tag = "R5"; req(3, 1, 5, 16'h00AA); req(0, 2, 5, 0);
    tag = "R6"; req(3, 1, 5, 16'h0BAD); req(0, 2, 5, 0);
    // R8: store elsewhere keeps, store on word clears
    tag = "R8"; req(2, 2, 5, 0); req(1, 3, 7, 16'h0777); req(3, 2, 5, 16'h0222);
    req(2, 2, 5, 0); req(1, 3, 5, 16'h0011); req(3, 2, 5, 16'h0333); req(0, 4, 5, 0);
    // R7: last usable edge, then first expired edge
    tag = "R7"; req(2, 4, 9, 0); idle(TIMEOUT - 1); req(3, 4, 9, 16'h0909);
    req(2, 4, 10, 0); idle(TIMEOUT); req(3, 4, 10, 16'h1010);
    req(2, 5, 11, 0); idle(TIMEOUT); req(2, 6, 11, 0); req(3, 6, 11, 16'h1111);
    // R9: holder refresh moves word and restarts lifetime
    tag = "R9"; req(2, 1, 2, 0); idle(10); req(2, 1, 3, 0); idle(15);
    req(3, 1, 2, 16'h2222); req(3, 1, 3, 16'h3333); req(0, 1, 3, 0);
    // R2: mixed traffic with colliding tags and words
    tag = "R2"; seed = 7;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[20:18] == 3'd0) idle(1 + int'(seed[25:23]));
      else req(int'(seed[17:16]), int'(seed[13:12]), int'(seed[9:8]), int'(seed[31:16]));
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule